// File: doc/BRIEF.md
# Framed CRC-16 Engine with Complemented Readout

This block computes a 16-bit cyclic redundancy check over one command frame of a single-wire memory slave, using the generator x^16 + x^15 + x^2 + 1. A frame-start pulse clears the checksum and records whether the frame is a write frame or a read frame. The surrounding command logic then offers the frame's bytes one at a time, in bus order. Each byte carries a tag that says what kind of byte it is. The engine shifts each accepted byte into the checksum one bit per clock, least significant bit first. While it does so, it holds its ready output low.

The engine follows the scratchpad offset of the frame. The starting offset comes from the first address byte, and each data byte moves it forward. The engine refuses bytes that do not belong in the checksum. It also raises a send-qualify output once the data has reached the last scratchpad offset. For a write frame this means the end offset is all ones. For a read frame it means the read ran through the end of the scratchpad. The checksum is always read out complemented, low byte first, and a pop input steps between the two bytes.

Top module: `crc16_frame_engine`

## Requirements
- R1: After reset the checksum is zero, `out_byte` is 0xFF (the complement of the zero low byte), `out_is_high` is 0, `crc_send` is 0 and `byte_ready` is 1.
- R2: The checksum uses generator x^16+x^15+x^2+1, processes bits least significant first, and starts from zero. A frame of the nine ASCII bytes "123456789" therefore yields 0xBB3D, which reads out as 0xC2 then 0x44.
- R3: A `frame_start` pulse clears the checksum, the readout position, the offset state and the end flag. It takes priority over a `byte_valid` in the same cycle, and that byte is not absorbed.
- R4: A byte is taken when `byte_valid` and `byte_ready` are both high. `byte_ready` then stays low for exactly 8 cycles. A `byte_valid` while `byte_ready` is low has no effect.
- R5: `out_byte` shows the bitwise complement of the checksum, low byte first (`out_is_high`=0). Each `out_pop` while ready moves to the high byte, and the next pop wraps back to the low byte.
- R6: Tag codes are 0 command, 1 address, 2 status, 3 data. In a write frame (`frame_is_read`=0 at `frame_start`), a status-tagged byte is refused: `byte_ready` stays high and the checksum is unchanged. In a read frame the status byte is absorbed.
- R7: The low 3 bits of the first address byte in a frame set the starting offset, and later address bytes leave it unchanged. Each absorbed data byte advances the offset by one. Once a data byte at offset 7 has been absorbed, further data bytes are refused and leave the checksum unchanged.
- R8: `crc_send` is high exactly when `byte_ready` is high and a data byte at offset 7 has been absorbed in the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Clears the engine and begins a new frame |
| frame_is_read | input | 1 | Frame kind sampled at frame_start: 1 read, 0 write |
| byte_valid | input | 1 | Offers byte_data with byte_tag |
| byte_tag | input | 2 | 0 command, 1 address, 2 status, 3 data |
| byte_data | input | 8 | Byte to absorb |
| byte_ready | output | 1 | High when a byte may be offered |
| out_pop | input | 1 | Advances the readout to the other checksum byte |
| out_byte | output | 8 | Complemented checksum byte at the current readout position |
| out_is_high | output | 1 | 1 when out_byte is the high byte |
| crc_send | output | 1 | Checksum should be transmitted for this frame |

## Verification
The bench runs complete write frames and read frames that start at different offsets and carry different numbers of data bytes. Some frames stop short of the last offset, some end exactly on it, and some overrun it. Comparing each result with a bit-level model shows whether the generator, the bit order and the coverage are right. The qualify output separates frames that reach the end from frames that fall short. The overrunning frames show that excess data is kept out of the checksum. Directed cases use the standard check string to catch a reflected or non-reflected generator, and the readout order to catch swapped or uncomplemented bytes. They also cover status bytes in write frames, offers while busy, and a frame start that collides with a byte offer.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam int CRC_W = 16;
    // x^16 + x^15 + x^2 + 1, bit-reversed for LSB-first shifting
    localparam logic [CRC_W-1:0] POLY_REFL = 16'hA001;

    typedef enum logic [1:0] {
        TAG_CMD  = 2'd0,
        TAG_ADDR = 2'd1,
        TAG_STAT = 2'd2,
        TAG_DATA = 2'd3
    } byte_tag_e;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur, input logic bit_in);
        logic fb;
        logic [CRC_W-1:0] nxt;
        fb  = cur[0] ^ bit_in;
        nxt = cur >> 1;
        if (fb) nxt = nxt ^ POLY_REFL;
        return nxt;
    endfunction

endpackage

// File: rtl/crc16_bit_core.sv
module crc16_bit_core
    import crc16_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) crc_q <= '0;
        else if (bit_valid) crc_q <= crc_step(crc_q, bit_in);
    end

    assign crc = crc_q;

    a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear |=> (crc_q == '0));
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!clear && !bit_valid) |=> $stable(crc_q));
endmodule

// File: rtl/crc16_byte_serializer.sv
module crc16_byte_serializer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [BYTE_W-1:0] data,
    output logic              bit_valid,
    output logic              bit_out,
    output logic              busy
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
    } ser_state_t;

    ser_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (st_q.busy) begin
            st_d.shreg = st_q.shreg >> 1;
            st_d.cnt   = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_BIT) st_d.busy = 1'b0;
        end else if (load) begin
            st_d.shreg = data;
            st_d.cnt   = '0;
            st_d.busy  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bit_valid = st_q.busy;
    assign bit_out   = st_q.shreg[0];
    assign busy      = st_q.busy;

    a_r4_no_load_busy: assert property (@(posedge clk) disable iff (rst)
        st_q.busy |-> !load);
    a_r4_start_after_load: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.busy) |-> $past(load));
endmodule

// File: rtl/crc16_frame_tracker.sv
module crc16_frame_tracker
    import crc16_pkg::*;
#(
    parameter int SPAD_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clear,
    input  logic                          kind_read_in,
    input  logic                          offer,
    input  logic [1:0]                    tag,
    input  logic [$clog2(SPAD_BYTES)-1:0] addr_low,
    output logic                          accept,
    output logic                          end_hit
);
    localparam int OFF_W = $clog2(SPAD_BYTES);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SPAD_BYTES - 1);

    logic             kind_read_q;
    logic             addr_seen_q;
    logic [OFF_W-1:0] cur_off_q;
    logic             end_hit_q;
    byte_tag_e        tag_e;

    assign tag_e = byte_tag_e'(tag);

    always_comb begin
        accept = offer;
        if (tag_e == TAG_STAT && !kind_read_q) accept = 1'b0;
        if (tag_e == TAG_DATA && end_hit_q)    accept = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_read_q <= 1'b0;
            addr_seen_q <= 1'b0;
            cur_off_q   <= '0;
            end_hit_q   <= 1'b0;
        end else if (clear) begin
            kind_read_q <= kind_read_in;
            addr_seen_q <= 1'b0;
            cur_off_q   <= '0;
            end_hit_q   <= 1'b0;
        end else if (accept) begin
            if (tag_e == TAG_ADDR && !addr_seen_q) begin
                addr_seen_q <= 1'b1;
                cur_off_q   <= addr_low;
            end
            if (tag_e == TAG_DATA) begin
                if (cur_off_q == LAST_OFF) end_hit_q <= 1'b1;
                cur_off_q <= cur_off_q + 1'b1;
            end
        end
    end

    assign end_hit = end_hit_q;

    a_r7_overrun_frozen: assert property (@(posedge clk) disable iff (rst)
        (offer && !clear && tag_e == TAG_DATA && end_hit_q) |=> ($stable(cur_off_q) && end_hit_q));
    a_r7_end_sticky: assert property (@(posedge clk) disable iff (rst)
        (end_hit_q && !clear) |=> end_hit_q);
endmodule

// File: rtl/crc16_frame_engine.sv
module crc16_frame_engine
    import crc16_pkg::*;
#(
    parameter int SPAD_BYTES = 8,
    parameter int BYTE_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              frame_is_read,
    input  logic              byte_valid,
    input  logic [1:0]        byte_tag,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_ready,
    input  logic              out_pop,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_is_high,
    output logic              crc_send
);
    localparam int OFF_W = $clog2(SPAD_BYTES);

    logic             busy;
    logic             offer;
    logic             accept;
    logic             end_hit;
    logic             bit_valid;
    logic             bit_sh;
    logic [CRC_W-1:0] crc;
    logic             hi_q;
    logic [CRC_W-1:0] crc_inv;

    assign byte_ready = !busy;
    assign offer      = byte_valid && !busy && !frame_start;

    crc16_frame_tracker #(.SPAD_BYTES(SPAD_BYTES)) u_track (
        .clk          (clk),
        .rst          (rst),
        .clear        (frame_start),
        .kind_read_in (frame_is_read),
        .offer        (offer),
        .tag          (byte_tag),
        .addr_low     (byte_data[OFF_W-1:0]),
        .accept       (accept),
        .end_hit      (end_hit)
    );

    crc16_byte_serializer #(.BYTE_W(BYTE_W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .clear     (frame_start),
        .load      (accept),
        .data      (byte_data),
        .bit_valid (bit_valid),
        .bit_out   (bit_sh),
        .busy      (busy)
    );

    crc16_bit_core u_core (
        .clk       (clk),
        .rst       (rst),
        .clear     (frame_start),
        .bit_valid (bit_valid),
        .bit_in    (bit_sh),
        .crc       (crc)
    );

    always_ff @(posedge clk) begin
        if (rst || frame_start) hi_q <= 1'b0;
        else if (out_pop && !busy) hi_q <= !hi_q;
    end

    assign crc_inv     = ~crc;
    assign out_byte    = hi_q ? crc_inv[2*BYTE_W-1:BYTE_W] : crc_inv[BYTE_W-1:0];
    assign out_is_high = hi_q;
    assign crc_send    = end_hit && !busy;

    a_r5_pop_toggles: assert property (@(posedge clk) disable iff (rst)
        (out_pop && !busy && !frame_start) |=> (hi_q != $past(hi_q)));
    a_r8_send_when_idle: assert property (@(posedge clk) disable iff (rst)
        crc_send |-> byte_ready);
    a_r6_refused_no_change: assert property (@(posedge clk) disable iff (rst)
        (offer && !accept) |=> ($stable(crc) && byte_ready));
    a_r3_start_priority: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (byte_ready && !crc_send && !out_is_high));
endmodule

// File: tb/tb_crc16_frame_engine.sv
module tb_crc16_frame_engine;

    logic       clk = 1'b0;
    logic       rst;
    logic       frame_start, frame_is_read, byte_valid, out_pop;
    logic [1:0] byte_tag;
    logic [7:0] byte_data;
    logic       byte_ready, out_is_high, crc_send;
    logic [7:0] out_byte;

    int checks = 0;
    int errors = 0;
    logic [15:0] model;

    always #2.5 clk = ~clk;

    crc16_frame_engine dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_is_read(frame_is_read),
        .byte_valid(byte_valid), .byte_tag(byte_tag), .byte_data(byte_data),
        .byte_ready(byte_ready), .out_pop(out_pop), .out_byte(out_byte),
        .out_is_high(out_is_high), .crc_send(crc_send)
    );

    // {is_read, ta1, data_count, seed}
    localparam logic [20:0] VEC [6] = '{
        {1'b0, 8'h00, 4'd8, 8'h10},
        {1'b0, 8'h03, 4'd2, 8'h20},
        {1'b1, 8'h05, 4'd3, 8'h30},
        {1'b1, 8'h01, 4'd4, 8'h40},
        {1'b0, 8'h06, 4'd5, 8'h50},
        {1'b1, 8'h07, 4'd1, 8'h60}
    };

    function automatic logic [15:0] mstep(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ 16'hA001;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start_frame(input logic rd);
        @(negedge clk);
        frame_start = 1'b1; frame_is_read = rd;
        @(negedge clk);
        frame_start = 1'b0;
        model = 16'h0000;
    endtask

    task automatic send_byte(input logic [1:0] tag, input logic [7:0] d);
        @(negedge clk);
        byte_valid = 1'b1; byte_tag = tag; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0;
        while (!byte_ready) @(negedge clk);
    endtask

    task automatic check_readout(input string req, input logic [15:0] exp);
        logic [15:0] inv;
        inv = ~exp;
        check(req, {out_is_high, out_byte}, {1'b0, inv[7:0]});
        @(negedge clk); out_pop = 1'b1;
        @(negedge clk); out_pop = 1'b0;
        check(req, {out_is_high, out_byte}, {1'b1, inv[15:8]});
        @(negedge clk); out_pop = 1'b1;
        @(negedge clk); out_pop = 1'b0;
        check(req, {24'd0, out_is_high}, 32'd0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int busy_cnt;
        logic [15:0] held;
        rst = 1'b1; frame_start = 0; frame_is_read = 0; byte_valid = 0;
        out_pop = 0; byte_tag = 0; byte_data = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", {out_byte, out_is_high, crc_send, byte_ready}, {8'hFF, 1'b0, 1'b0, 1'b1});

        // Table walk: R2 R7 R8 coverage per frame kind
        for (int v = 0; v < 6; v++) begin
            logic rd;
            logic [7:0] ta1, seed;
            logic [3:0] n;
            int off;
            logic exp_send;
            {rd, ta1, n, seed} = VEC[v];
            start_frame(rd);
            send_byte(2'd0, rd ? 8'hF0 : 8'h0F); model = mstep(model, rd ? 8'hF0 : 8'h0F);
            send_byte(2'd1, ta1);                model = mstep(model, ta1);
            send_byte(2'd1, 8'h00);              model = mstep(model, 8'h00);
            if (rd) begin
                send_byte(2'd2, ta1 ^ 8'h5A);    model = mstep(model, ta1 ^ 8'h5A);
            end
            off = int'(ta1[2:0]);
            exp_send = 1'b0;
            for (int i = 0; i < int'(n); i++) begin
                send_byte(2'd3, seed + 8'(i));
                if (!exp_send) begin
                    model = mstep(model, seed + 8'(i));
                    if (off == 7) exp_send = 1'b1;
                    off++;
                end
            end
            check("R8", {31'd0, crc_send}, {31'd0, exp_send});
            check_readout("R7", model);
        end

        // R2 check string through command tags
        start_frame(1'b0);
        for (int i = 0; i < 9; i++) send_byte(2'd0, 8'h31 + 8'(i));
        check("R2", {24'd0, out_byte}, 32'h0000_00C2);
        check_readout("R2", 16'hBB3D);

        // R4 ready low exactly 8 cycles; offer while busy ignored
        start_frame(1'b1);
        @(negedge clk);
        byte_valid = 1'b1; byte_tag = 2'd0; byte_data = 8'hA5;
        @(negedge clk);
        byte_tag = 2'd0; byte_data = 8'h3C;   // still valid while busy
        busy_cnt = 0;
        while (!byte_ready && busy_cnt < 20) begin
            busy_cnt++;
            @(negedge clk);
            if (busy_cnt == 3) byte_valid = 1'b0;
        end
        byte_valid = 1'b0;
        check("R4", busy_cnt, 8);
        @(negedge clk);
        model = mstep(16'h0000, 8'hA5);
        check_readout("R4", model);

        // R6 status byte refused in write frame
        start_frame(1'b0);
        send_byte(2'd0, 8'h0F);
        held = mstep(16'h0000, 8'h0F);
        @(negedge clk);
        byte_valid = 1'b1; byte_tag = 2'd2; byte_data = 8'h77;
        @(negedge clk);
        byte_valid = 1'b0;
        check("R6", {31'd0, byte_ready}, 32'd1);
        check_readout("R6", held);

        // R7 second address byte does not move offset; overrun refused
        start_frame(1'b0);
        send_byte(2'd1, 8'h06);
        send_byte(2'd1, 8'h01);
        send_byte(2'd3, 8'h11);
        check("R7", {31'd0, crc_send}, 32'd0);
        send_byte(2'd3, 8'h22);
        check("R8", {31'd0, crc_send}, 32'd1);
        send_byte(2'd3, 8'h33);
        model = mstep(mstep(mstep(mstep(16'h0000, 8'h06), 8'h01), 8'h11), 8'h22);
        check_readout("R7", model);

        // R3 frame_start wins over same-cycle byte
        @(negedge clk);
        out_pop = 1'b1;
        @(negedge clk);
        out_pop = 1'b0;
        frame_start = 1'b1; frame_is_read = 1'b0;
        byte_valid = 1'b1; byte_tag = 2'd0; byte_data = 8'hC3;
        @(negedge clk);
        frame_start = 1'b0; byte_valid = 1'b0;
        check("R3", {out_byte, out_is_high, crc_send, byte_ready}, {8'hFF, 1'b0, 1'b0, 1'b1});
        check_readout("R3", 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule